// File: doc/BRIEF.md
# I2C Interrupt Flag Controller

This block gathers the interrupt events of an I2C controller into one sticky status register. A separate enable register selects which of those events may reach the CPU. The I2C bit and shift engine lives elsewhere and sends single-cycle event pulses into this block. The block also watches the sampled SCL line while the controller is master. If SCL stays low for too long, or if a START cannot be issued, it raises a timeout flag. While the clock-stretch flag is pending, it asks the engine to hold SCL low.

Software uses a small synchronous register bus with four word addresses: status at 0, interrupt enable at 1, timeout limit at 2, and control at 3. A flag can only be cleared by software. A few flags can also be set by software, so that an interrupt can be forced. Two outputs leave the block: a single registered CPU interrupt line and a registered SCL hold-low request.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset, all four registers read 0, and `irq_o` and `scl_hold_o` are low.
- R2: The status bits are set by these hardware events, and each bit stays set until software clears it: bit 0 START or repeated START, bit 1 byte sent with its acknowledge slot received, bit 2 byte received, bit 3 clock stretch, bit 4 timeout, bit 5 address match, bit 6 arbitration lost, bit 7 NACK, bit 8 general call, bit 9 receive overrun, bit 11 STOP.
- R3: Writing the status register with a 0 in a bit clears that flag. Writing a 1 to bit 0, bit 1 or bit 4 sets that flag.
- R4: Writing a 1 to status bits 2, 3, 5 to 9 or 11 leaves the flag unchanged. Status bits 10 and 15:12 always read 0.
- R5: The enable register at address 1 uses the same bit positions as the status register. Enable bits 10 and 15:12 read 0 and ignore writes.
- R6: `irq_o` is the registered OR of (flag AND enable) over all defined bits. It rises on the clock after the flag is set and falls on the clock after the flag is cleared.
- R7: The general-call flag can raise `irq_o` only while control bit 1 (general-call recognition) is 1 and enable bit 8 is 1.
- R8: A stretch event sets status bit 3 only while control bit 0 (stretch enable) is 1. `scl_hold_o` is high from the clock after bit 3 is set until the clock after software clears it.
- R9: In master mode, with a nonzero limit L at address 2, status bit 4 is set on the (L+1)th consecutive clock in which SCL is sampled low. The count restarts whenever SCL is sampled high or master mode is off.
- R10: A timeout limit of 0 disables SCL-low timeout detection.
- R11: A pulse on `start_blocked_i` sets status bit 4.
- R12: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R13: Read data is registered. It shows the register selected by `bus_addr_i` one clock later. The control register holds 2 bits and the timeout limit holds 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 2 | Register word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| ev_start_i | input | 1 | START or repeated START seen |
| ev_stop_i | input | 1 | STOP seen |
| ev_rx_i | input | 1 | Data byte received |
| ev_tx_i | input | 1 | Byte sent and acknowledge slot received |
| ev_nack_i | input | 1 | NACK seen |
| ev_arb_i | input | 1 | Arbitration lost |
| ev_amatch_i | input | 1 | Own address matched |
| ev_gcall_i | input | 1 | General call address seen |
| ev_ovr_i | input | 1 | Receive overrun |
| ev_stretch_i | input | 1 | Engine requests a clock stretch |
| start_blocked_i | input | 1 | START could not be issued because the bus is busy |
| master_i | input | 1 | Controller is operating as master |
| scl_i | input | 1 | Sampled SCL line |
| irq_o | output | 1 | CPU interrupt request |
| scl_hold_o | output | 1 | Request to hold SCL low |

## Verification
A hardware event and a software write of 0 to the status register can land on the same clock edge. The bench provokes this by pulsing the START event in the same cycle as a status write of all zeros, after first setting the receive flag. It judges the result by reading back status: only bit 0 may remain. A second overlap is a timeout firing while the clock-stretch hold is active; these two paths are tested one after the other, and the flag-set-versus-clear race is also watched cycle by cycle by a property.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STAT = 2'd0,
    ADR_IEN  = 2'd1,
    ADR_TOUT = 2'd2,
    ADR_CTRL = 2'd3
  } reg_addr_e;

  // flag positions shared by the status and enable registers
  localparam int B_START   = 0;
  localparam int B_TXDONE  = 1;
  localparam int B_RXRDY   = 2;
  localparam int B_STRETCH = 3;
  localparam int B_TOUT    = 4;
  localparam int B_AMATCH  = 5;
  localparam int B_ARBLOST = 6;
  localparam int B_NACK    = 7;
  localparam int B_GCALL   = 8;
  localparam int B_OVRUN   = 9;
  localparam int B_STOP    = 11;

  localparam logic [REG_W-1:0] FLAG_MASK   = 16'h0BFF;
  localparam logic [REG_W-1:0] SW_SET_MASK = 16'h0013;

  // control register fields
  localparam int C_STRETCH_EN = 0;
  localparam int C_GCALL_EN   = 1;
endpackage

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
  parameter int                W     = 16,
  parameter logic [W-1:0]      VALID = '1,
  parameter logic [W-1:0]      SWSET = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flag_q;
  logic [W-1:0] sw_next;
  logic [W-1:0] flag_d;

  // a written 0 clears, a written 1 sets only settable bits, else keeps
  always_comb begin
    sw_next = wr_i ? (wdata_i & (flag_q | SWSET)) : flag_q;
    flag_d  = (sw_next | hw_set_i) & VALID;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) flag_q <= '0;
    else       flag_q <= flag_d;
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/i2c_scl_timeout.sv
module i2c_scl_timeout #(
  parameter int TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            master_i,
  input  logic            scl_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            fire_o
);
  localparam int CNT_W = TO_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_ext;
  logic             reload;

  assign limit_ext = {1'b0, limit_i};
  assign reload    = !master_i || scl_i || (limit_i == '0);

  // counts consecutive low samples, stops one past the limit
  always_ff @(posedge clk_i) begin
    if (rst_i || reload)        cnt_q <= '0;
    else if (cnt_q <= limit_ext) cnt_q <= cnt_q + 1'b1;
  end

  assign fire_o = !reload && (cnt_q == limit_ext);
endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
  import i2c_irq_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  flags_i,
  output logic              stat_wr_o,
  output logic [REG_W-1:0]  ien_o,
  output logic [TO_W-1:0]   tout_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [REG_W-1:0]  rdata_o
);
  reg_addr_e         sel;
  logic [REG_W-1:0]  ien_q;
  logic [TO_W-1:0]   tout_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [REG_W-1:0]  rd_mux;
  logic [REG_W-1:0]  rd_q;

  assign sel       = reg_addr_e'(addr_i);
  assign stat_wr_o = wr_i && (sel == ADR_STAT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ien_q  <= '0;
      tout_q <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      case (sel)
        ADR_IEN:  ien_q  <= wdata_i & FLAG_MASK;
        ADR_TOUT: tout_q <= wdata_i[TO_W-1:0];
        ADR_CTRL: ctrl_q <= wdata_i[CTRL_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      ADR_STAT: rd_mux = flags_i;
      ADR_IEN:  rd_mux = ien_q;
      ADR_TOUT: rd_mux = REG_W'(tout_q);
      default:  rd_mux = REG_W'(ctrl_q);
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_q <= '0;
    else       rd_q <= rd_mux;
  end

  assign ien_o   = ien_q;
  assign tout_o  = tout_q;
  assign ctrl_o  = ctrl_q;
  assign rdata_o = rd_q;
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic              ev_start_i,
  input  logic              ev_stop_i,
  input  logic              ev_rx_i,
  input  logic              ev_tx_i,
  input  logic              ev_nack_i,
  input  logic              ev_arb_i,
  input  logic              ev_amatch_i,
  input  logic              ev_gcall_i,
  input  logic              ev_ovr_i,
  input  logic              ev_stretch_i,
  input  logic              start_blocked_i,
  input  logic              master_i,
  input  logic              scl_i,
  output logic              irq_o,
  output logic              scl_hold_o
);
  logic              stat_wr;
  logic [REG_W-1:0]  flag_q;
  logic [REG_W-1:0]  ien_q;
  logic [TO_W-1:0]   tout_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [REG_W-1:0]  hw_set;
  logic [REG_W-1:0]  irq_gate;
  logic              to_fire;
  logic              irq_q;
  logic              hold_q;

  i2c_irq_regs #(.TO_W(TO_W)) u_regs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .addr_i    (bus_addr_i),
    .wr_i      (bus_wr_i),
    .wdata_i   (bus_wdata_i),
    .flags_i   (flag_q),
    .stat_wr_o (stat_wr),
    .ien_o     (ien_q),
    .tout_o    (tout_q),
    .ctrl_o    (ctrl_q),
    .rdata_o   (bus_rdata_o)
  );

  i2c_scl_timeout #(.TO_W(TO_W)) u_tout (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .master_i (master_i),
    .scl_i    (scl_i),
    .limit_i  (tout_q),
    .fire_o   (to_fire)
  );

  always_comb begin
    hw_set            = '0;
    hw_set[B_START]   = ev_start_i;
    hw_set[B_TXDONE]  = ev_tx_i;
    hw_set[B_RXRDY]   = ev_rx_i;
    hw_set[B_STRETCH] = ev_stretch_i && ctrl_q[C_STRETCH_EN];
    hw_set[B_TOUT]    = to_fire || start_blocked_i;
    hw_set[B_AMATCH]  = ev_amatch_i;
    hw_set[B_ARBLOST] = ev_arb_i;
    hw_set[B_NACK]    = ev_nack_i;
    hw_set[B_GCALL]   = ev_gcall_i;
    hw_set[B_OVRUN]   = ev_ovr_i;
    hw_set[B_STOP]    = ev_stop_i;
  end

  i2c_irq_flags #(
    .W     (REG_W),
    .VALID (FLAG_MASK),
    .SWSET (SW_SET_MASK)
  ) u_flags (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_i     (stat_wr),
    .wdata_i  (bus_wdata_i),
    .hw_set_i (hw_set),
    .flags_o  (flag_q)
  );

  // general call reaches the CPU only while recognition is on
  always_comb begin
    irq_gate          = FLAG_MASK;
    irq_gate[B_GCALL] = ctrl_q[C_GCALL_EN];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      irq_q  <= |(flag_q & ien_q & irq_gate);
      hold_q <= flag_q[B_STRETCH] && ctrl_q[C_STRETCH_EN];
    end
  end

  assign irq_o      = irq_q;
  assign scl_hold_o = hold_q;
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
  import i2c_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [REG_W-1:0]  bus_wdata_i,
  input logic              ev_start_i,
  input logic              ev_rx_i,
  input logic              irq_o,
  input logic              scl_hold_o,
  input logic [REG_W-1:0]  flags_i,
  input logic [REG_W-1:0]  ien_i,
  input logic [CTRL_W-1:0] ctrl_i
);
  logic stat_wr;
  logic ien_wr;
  logic pend;

  assign stat_wr = bus_wr_i && (bus_addr_i == ADR_STAT);
  assign ien_wr  = bus_wr_i && (bus_addr_i == ADR_IEN);
  assign pend    = |(flags_i & ien_i & ~(REG_W'(!ctrl_i[C_GCALL_EN]) << B_GCALL));

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !stat_wr |=> ((flags_i & $past(flags_i)) == $past(flags_i)));

  assert_rx_hw_only_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !ev_rx_i |=> !$rose(flags_i[B_RXRDY]));

  assert_ien_reserved_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    ien_wr |=> (ien_i == ($past(bus_wdata_i) & FLAG_MASK)));

  assert_irq_rise_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    pend |=> irq_o);

  assert_irq_fall_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !pend |=> !irq_o);

  assert_hold_src_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    scl_hold_o |-> $past(flags_i[B_STRETCH] && ctrl_i[C_STRETCH_EN]));

  assert_set_wins_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_start_i |=> flags_i[B_START]);
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .ev_start_i  (ev_start_i),
  .ev_rx_i     (ev_rx_i),
  .irq_o       (irq_o),
  .scl_hold_o  (scl_hold_o),
  .flags_i     (flag_q),
  .ien_i       (ien_q),
  .ctrl_i      (ctrl_q)
);

// File: tb/i2c_irq_ctrl_bench.sv
module i2c_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic ev_start = 0, ev_stop = 0, ev_rx = 0, ev_tx = 0, ev_nack = 0, ev_arb = 0;
  logic ev_amatch = 0, ev_gcall = 0, ev_ovr = 0, ev_stretch = 0, blocked = 0;
  logic master = 1'b0;
  logic scl = 1'b1;
  logic irq, hold;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_irq_ctrl u_i2c_irq_ctrl (
    .clk_i (clk), .rst_i (rst),
    .bus_addr_i (addr), .bus_wr_i (wr), .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .ev_start_i (ev_start), .ev_stop_i (ev_stop), .ev_rx_i (ev_rx), .ev_tx_i (ev_tx),
    .ev_nack_i (ev_nack), .ev_arb_i (ev_arb), .ev_amatch_i (ev_amatch),
    .ev_gcall_i (ev_gcall), .ev_ovr_i (ev_ovr), .ev_stretch_i (ev_stretch),
    .start_blocked_i (blocked), .master_i (master), .scl_i (scl),
    .irq_o (irq), .scl_hold_o (hold)
  );

  // {event mask by status bit, expected status}; control is 0 during the walk
  localparam logic [31:0] VEC_TBL [13] = '{
    32'h0001_0001, 32'h0002_0002, 32'h0004_0004, 32'h0008_0000,
    32'h0010_0010, 32'h0020_0020, 32'h0040_0040, 32'h0080_0080,
    32'h0100_0100, 32'h0200_0200, 32'h0800_0800, 32'h0A45_0A45,
    32'h0BF7_0BF7
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; wr = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic drive_evt(input logic [15:0] m);
    ev_start = m[0]; ev_tx = m[1]; ev_rx = m[2]; ev_stretch = m[3]; blocked = m[4];
    ev_amatch = m[5]; ev_arb = m[6]; ev_nack = m[7]; ev_gcall = m[8]; ev_ovr = m[9];
    ev_stop = m[11];
  endtask

  task automatic pulse_evt(input logic [15:0] m);
    @(negedge clk); drive_evt(m);
    @(negedge clk); drive_evt(16'h0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R13: reset values through the registered read port
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 hold", {15'd0, hold}, 16'd0);
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), v);
      check("R1 reg", v, 16'h0000);
    end

    // R2 / R3: table walk of hardware events, then clear with a 0 write
    for (int i = 0; i < 13; i++) begin
      pulse_evt(VEC_TBL[i][31:16]);
      repeat (2) @(negedge clk);
      bus_read(2'd0, v);
      check("R2 event sets sticky flag", v, VEC_TBL[i][15:0]);
      bus_write(2'd0, 16'h0000);
      bus_read(2'd0, v);
      check("R3 zero write clears", v, 16'h0000);
    end

    // R3: software set of the settable bits
    bus_write(2'd0, 16'h0013);
    bus_read(2'd0, v);
    check("R3 software set", v, 16'h0013);
    // R4: ones into hardware-only bits change nothing, zeros clear
    pulse_evt(16'h0004);
    bus_write(2'd0, 16'hFFEC);
    bus_read(2'd0, v);
    check("R4 hw-only ignore", v, 16'h0004);
    bus_write(2'd0, 16'h0000);

    // R5 / R13: enable, timeout and control read back
    bus_write(2'd1, 16'hFFFF);
    bus_read(2'd1, v);
    check("R5 enable reserved", v, 16'h0BFF);
    bus_write(2'd2, 16'h1234);
    bus_read(2'd2, v);
    check("R13 timeout reg", v, 16'h1234);
    bus_write(2'd3, 16'hFFFF);
    bus_read(2'd3, v);
    check("R13 control reg", v, 16'h0003);
    bus_write(2'd3, 16'h0000);

    // R6: interrupt timing
    bus_write(2'd1, 16'h0002);
    pulse_evt(16'h0002);
    check("R6 irq not yet", {15'd0, irq}, 16'd0);
    @(negedge clk);
    check("R6 irq rises", {15'd0, irq}, 16'd1);
    bus_write(2'd0, 16'h0000);
    @(negedge clk);
    check("R6 irq falls", {15'd0, irq}, 16'd0);
    bus_write(2'd1, 16'h0001);
    pulse_evt(16'h0002);
    repeat (2) @(negedge clk);
    check("R6 masked", {15'd0, irq}, 16'd0);
    bus_write(2'd0, 16'h0000);

    // R7: general call gated by recognition enable
    bus_write(2'd1, 16'h0100);
    pulse_evt(16'h0100);
    repeat (2) @(negedge clk);
    check("R7 gcall gated", {15'd0, irq}, 16'd0);
    bus_write(2'd3, 16'h0002);
    @(negedge clk);
    check("R7 gcall fires", {15'd0, irq}, 16'd1);
    bus_write(2'd0, 16'h0000);
    bus_write(2'd3, 16'h0000);
    bus_write(2'd1, 16'h0000);

    // R8: clock stretch hold
    bus_write(2'd3, 16'h0001);
    pulse_evt(16'h0008);
    check("R8 hold registered", {15'd0, hold}, 16'd0);
    @(negedge clk);
    check("R8 hold on", {15'd0, hold}, 16'd1);
    repeat (3) @(negedge clk);
    check("R8 hold stays", {15'd0, hold}, 16'd1);
    bus_write(2'd0, 16'h0000);
    @(negedge clk);
    check("R8 hold released", {15'd0, hold}, 16'd0);
    bus_write(2'd3, 16'h0000);

    // R9: SCL-low timeout at limit 5 fires on the sixth low sample
    bus_write(2'd1, 16'h0010);
    bus_write(2'd2, 16'd5);
    master = 1'b1;
    @(negedge clk); scl = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 no early timeout", {15'd0, irq}, 16'd0);
    @(negedge clk);
    check("R9 timeout irq", {15'd0, irq}, 16'd1);
    scl = 1'b1;
    bus_write(2'd0, 16'h0000);
    bus_write(2'd1, 16'h0000);
    // R9: restart on high sample and outside master mode
    scl = 1'b0; repeat (4) @(negedge clk);
    scl = 1'b1; @(negedge clk);
    scl = 1'b0; repeat (4) @(negedge clk);
    scl = 1'b1;
    master = 1'b0; scl = 1'b0; repeat (20) @(negedge clk);
    scl = 1'b1;
    bus_read(2'd0, v);
    check("R9 count restarts", v, 16'h0000);

    // R10: limit 0 disables
    bus_write(2'd2, 16'd0);
    master = 1'b1; scl = 1'b0;
    repeat (40) @(negedge clk);
    bus_read(2'd0, v);
    check("R10 zero limit", v, 16'h0000);
    scl = 1'b1; master = 1'b0;

    // R11: START blocked sets timeout
    pulse_evt(16'h0010);
    bus_read(2'd0, v);
    check("R11 start blocked", v, 16'h0010);
    bus_write(2'd0, 16'h0000);

    // R12: hardware set beats software clear in the same cycle
    pulse_evt(16'h0004);
    @(negedge clk);
    addr = 2'd0; wdata = 16'h0000; wr = 1'b1; drive_evt(16'h0001);
    @(negedge clk);
    wr = 1'b0; drive_evt(16'h0000);
    bus_read(2'd0, v);
    check("R12 set wins", v, 16'h0001);

    finish_run();
  end
endmodule